// File: doc/BRIEF.md
# Embedded Controller Command Sequencer

This block runs one command transaction against an embedded controller that sits behind a pair of byte ports, in the style of a keyboard controller. One port is for command and status. The other port carries data. A requester pulses `start` together with a command byte, an argument count, a response count and a timeout in milliseconds. The sequencer then:

1. Throws away any stale output that the controller still holds.
2. Waits for the controller's input buffer to empty.
3. Writes the command byte.
4. Feeds the argument bytes one by one, each taken through a valid/ready stream.
5. Collects the response bytes, each delivered through a one-cycle valid strobe.

Every step paces itself by polling the status port. A millisecond prescaler, derived from a clock parameter, bounds each wait.

Two kinds of failure are handled differently:

- **Input side.** A stall on the input side is unrecoverable, so the transaction ends with `err`.
- **Response side.** A stall while waiting for a response byte re-issues the whole command, starting from the command write and replaying the stored arguments. A parameterised limit on these re-issues ensures that a dead controller cannot hold the sequencer for ever.

A wait that succeeds only after the 20 ms base window, under a longer programmed timeout, is flagged through a one-cycle `slow` strobe and does not count as a failure.

Top module: `ec_cmd_seq`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `slow`, `rsp_valid`, `arg_ready` and `bus_req` are all low, and the block stays quiet until `start`.
- R2: Before the command, the status port (`bus_addr`=1) is read. While status bit 0 (output buffer full) is set, one byte is read and discarded from the data port (`bus_addr`=0). At most DRAIN_MAX (10) such reads are made. If bit 0 is still set after that, the transaction ends with `err` and no command byte is written.
- R3: The command byte is written to the status/command port (`bus_addr`=1) only after status bit 1 (input buffer full) reads clear. After the write, the block again waits for bit 1 to clear.
- R4: Each argument byte waits for status bit 1 to clear. It is then taken from the `arg_valid`/`arg_ready` stream and written to the data port, in stream order.
- R5: Each response byte waits for status bit 0 to be set. It is then read from the data port and presented on `rsp_data` with a one-cycle `rsp_valid`, in arrival order. Stale drained bytes are never presented.
- R6: Each wait is bounded by `tmo_ms` milliseconds, where one millisecond is CYC_PER_MS clock cycles. A `tmo_ms` of 0 is invalid and selects 20 ms.
- R7: A timeout while waiting for the input buffer to empty ends the transaction with `err` at once.
- R8: A timeout while waiting for a response byte restarts at the command-byte write, with no drain and no initial quiesce. All argument bytes are replayed from internal storage without new stream handshakes.
- R9: When MAX_RESTARTS (3) restarts have already been made, the next response timeout ends the transaction with `err`. This gives MAX_RESTARTS+1 command writes in total.
- R10: If `tmo_ms` exceeds 20 and a wait succeeds after more than 20 elapsed milliseconds, `slow` pulses for one cycle and the transaction continues. Waits that finish within 20 ms never raise `slow`.
- R11: Each transaction ends with exactly one single-cycle pulse of either `done` or `err`, never both. A `start` while `busy` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transaction (sampled when idle) |
| cmd_byte | input | 8 | Command byte to issue |
| arg_count | input | CNT_W | Number of argument bytes (clamped to MAX_ARGS) |
| rsp_count | input | CNT_W | Number of response bytes |
| tmo_ms | input | TMO_W | Per-wait timeout in ms, 0 selects 20 |
| arg_valid | input | 1 | Argument byte available |
| arg_data | input | 8 | Argument byte |
| arg_ready | output | 1 | Sequencer takes the argument byte this cycle if valid |
| rsp_valid | output | 1 | Response byte strobe |
| rsp_data | output | 8 | Response byte |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle success pulse |
| err | output | 1 | One-cycle failure pulse |
| slow | output | 1 | One-cycle late-wait indication |
| bus_req | output | 1 | Controller port access this cycle |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 1 | 1 = command/status port, 0 = data port |
| bus_wdata | output | 8 | Write byte |
| bus_rdata | input | 8 | Read byte, valid in the same cycle as a read request |

## Verification
The port-ordering properties take for granted that the controller answers reads combinationally within the requesting cycle. They also assume that it keeps its input-buffer flag clear while it is expected to produce a response. That second assumption is what lets a restart write the command without a fresh quiesce read. The bench's controller model keeps within both assumptions: it returns status and data from registered state, and it raises the input-buffer flag only for a few cycles after each byte written to it. Stalls are produced only by holding that flag for a whole transaction or by withholding responses, never by changing the flag in the middle of the response phase.

// File: rtl/ec_seq_pkg.sv
package ec_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DRAIN,
        S_DRAIN_RD,
        S_QUIESCE,
        S_CMD_WR,
        S_CMD_ACK,
        S_ARG_WAIT,
        S_ARG_PUT,
        S_RSP_WAIT,
        S_RSP_RD
    } seq_state_e;

    // status register bit positions decoded from the controller
    localparam int IBF_BIT = 1;
    localparam int OBF_BIT = 0;

    // port select on the controller bus
    localparam logic PORT_DATA = 1'b0;
    localparam logic PORT_CTRL = 1'b1;

    // base wait window in milliseconds
    localparam int BASE_MS = 20;

    function automatic logic is_wait_state(input seq_state_e s);
        return (s == S_QUIESCE) || (s == S_CMD_ACK) ||
               (s == S_ARG_WAIT) || (s == S_RSP_WAIT);
    endfunction

endpackage

// File: rtl/ec_tick_gen.sv
module ec_tick_gen #(
    parameter int CYC_PER_MS = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic tick
);
    localparam int CW = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYC_PER_MS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clear || cnt_q == LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign tick = (cnt_q == LAST);

endmodule

// File: rtl/ec_wait_timer.sv
module ec_wait_timer #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             tick,
    input  logic [TMO_W-1:0] limit,
    output logic             expired,
    output logic [TMO_W-1:0] elapsed
);
    typedef struct packed {
        logic [TMO_W-1:0] rem;
        logic [TMO_W-1:0] el;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (arm) begin
            t_d.rem = limit;
            t_d.el  = '0;
        end else if (tick && t_q.rem != '0) begin
            t_d.rem = t_q.rem - TMO_W'(1);
            t_d.el  = t_q.el + TMO_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign expired = (t_q.rem == '0);
    assign elapsed = t_q.el;

endmodule

// File: rtl/ec_cmd_seq.sv
module ec_cmd_seq
    import ec_seq_pkg::*;
#(
    parameter int CYC_PER_MS   = 100000,
    parameter int TMO_W        = 8,
    parameter int MAX_ARGS     = 8,
    parameter int CNT_W        = 4,
    parameter int DRAIN_MAX    = 10,
    parameter int MAX_RESTARTS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       cmd_byte,
    input  logic [CNT_W-1:0] arg_count,
    input  logic [CNT_W-1:0] rsp_count,
    input  logic [TMO_W-1:0] tmo_ms,
    input  logic             arg_valid,
    input  logic [7:0]       arg_data,
    output logic             arg_ready,
    output logic             rsp_valid,
    output logic [7:0]       rsp_data,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic             slow,
    output logic             bus_req,
    output logic             bus_we,
    output logic             bus_addr,
    output logic [7:0]       bus_wdata,
    input  logic [7:0]       bus_rdata
);
    localparam int DRN_W = $clog2(DRAIN_MAX + 1);
    localparam int RST_W = (MAX_RESTARTS > 0) ? $clog2(MAX_RESTARTS + 1) : 1;
    localparam int AB_W  = (MAX_ARGS > 1) ? $clog2(MAX_ARGS) : 1;
    localparam logic [TMO_W-1:0] BASE_T   = TMO_W'(BASE_MS);
    localparam logic [CNT_W-1:0] ARG_CAP  = CNT_W'(MAX_ARGS);
    localparam logic [DRN_W-1:0] DRN_LAST = DRN_W'(DRAIN_MAX);
    localparam logic [RST_W-1:0] RST_LAST = RST_W'(MAX_RESTARTS);

    typedef struct packed {
        seq_state_e       st;
        logic [7:0]       cmd;
        logic [CNT_W-1:0] n_arg;
        logic [CNT_W-1:0] n_rsp;
        logic [CNT_W-1:0] idx;
        logic [TMO_W-1:0] tmo;
        logic [DRN_W-1:0] drn;
        logic [RST_W-1:0] rst;
        logic             rsp_v;
        logic [7:0]       rsp_b;
        logic             done;
        logic             err;
        logic             slow;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic             arm;
    logic             tick;
    logic             t_exp;
    logic [TMO_W-1:0] t_el;
    logic             late;
    logic             ibf;
    logic             obf;
    logic             replay;
    logic             ab_we;
    logic [AB_W-1:0]  ab_idx;
    logic [7:0]       abuf_q [MAX_ARGS];

    ec_tick_gen #(
        .CYC_PER_MS(CYC_PER_MS)
    ) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(arm),
        .tick (tick)
    );

    ec_wait_timer #(
        .TMO_W(TMO_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (arm),
        .tick   (tick),
        .limit  (r_q.tmo),
        .expired(t_exp),
        .elapsed(t_el)
    );

    // argument replay storage, one register per slot
    assign ab_idx = r_q.idx[AB_W-1:0];

    for (genvar g = 0; g < MAX_ARGS; g++) begin : g_abuf
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                abuf_q[g] <= '0;
            end else if (ab_we && ab_idx == AB_W'(g)) begin
                abuf_q[g] <= arg_data;
            end
        end
    end

    assign ibf    = bus_rdata[IBF_BIT];
    assign obf    = bus_rdata[OBF_BIT];
    assign late   = (r_q.tmo > BASE_T) && (t_el > BASE_T);
    assign replay = (r_q.rst != '0);

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.err   = 1'b0;
        r_d.slow  = 1'b0;
        r_d.rsp_v = 1'b0;
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = PORT_DATA;
        bus_wdata = '0;
        arg_ready = 1'b0;
        ab_we     = 1'b0;

        unique case (r_q.st)
            S_IDLE: begin
                if (start) begin
                    r_d.st    = S_DRAIN;
                    r_d.cmd   = cmd_byte;
                    r_d.n_arg = (arg_count > ARG_CAP) ? ARG_CAP : arg_count;
                    r_d.n_rsp = rsp_count;
                    r_d.tmo   = (tmo_ms == '0) ? BASE_T : tmo_ms;
                    r_d.drn   = '0;
                    r_d.rst   = '0;
                    r_d.idx   = '0;
                end
            end

            S_DRAIN: begin
                bus_req  = 1'b1;
                bus_addr = PORT_CTRL;
                if (!obf) begin
                    r_d.st = S_QUIESCE;
                end else if (r_q.drn == DRN_LAST) begin
                    r_d.err = 1'b1;
                    r_d.st  = S_IDLE;
                end else begin
                    r_d.st = S_DRAIN_RD;
                end
            end

            S_DRAIN_RD: begin
                bus_req = 1'b1;
                r_d.drn = r_q.drn + DRN_W'(1);
                r_d.st  = S_DRAIN;
            end

            S_QUIESCE: begin
                bus_req  = 1'b1;
                bus_addr = PORT_CTRL;
                if (!ibf) begin
                    r_d.slow = late;
                    r_d.st   = S_CMD_WR;
                end else if (t_exp) begin
                    r_d.err = 1'b1;
                    r_d.st  = S_IDLE;
                end
            end

            S_CMD_WR: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = PORT_CTRL;
                bus_wdata = r_q.cmd;
                r_d.idx   = '0;
                r_d.st    = S_CMD_ACK;
            end

            S_CMD_ACK: begin
                bus_req  = 1'b1;
                bus_addr = PORT_CTRL;
                if (!ibf) begin
                    r_d.slow = late;
                    if (r_q.n_arg != '0) begin
                        r_d.st = S_ARG_WAIT;
                    end else if (r_q.n_rsp != '0) begin
                        r_d.st = S_RSP_WAIT;
                    end else begin
                        r_d.done = 1'b1;
                        r_d.st   = S_IDLE;
                    end
                end else if (t_exp) begin
                    r_d.err = 1'b1;
                    r_d.st  = S_IDLE;
                end
            end

            S_ARG_WAIT: begin
                bus_req  = 1'b1;
                bus_addr = PORT_CTRL;
                if (!ibf) begin
                    r_d.slow = late;
                    r_d.st   = S_ARG_PUT;
                end else if (t_exp) begin
                    r_d.err = 1'b1;
                    r_d.st  = S_IDLE;
                end
            end

            S_ARG_PUT: begin
                arg_ready = !replay;
                if (replay || arg_valid) begin
                    bus_req   = 1'b1;
                    bus_we    = 1'b1;
                    bus_wdata = replay ? abuf_q[ab_idx] : arg_data;
                    ab_we     = !replay;
                    if (r_q.idx + CNT_W'(1) == r_q.n_arg) begin
                        r_d.idx = '0;
                        if (r_q.n_rsp != '0) begin
                            r_d.st = S_RSP_WAIT;
                        end else begin
                            r_d.done = 1'b1;
                            r_d.st   = S_IDLE;
                        end
                    end else begin
                        r_d.idx = r_q.idx + CNT_W'(1);
                        r_d.st  = S_ARG_WAIT;
                    end
                end
            end

            S_RSP_WAIT: begin
                bus_req  = 1'b1;
                bus_addr = PORT_CTRL;
                if (obf) begin
                    r_d.slow = late;
                    r_d.st   = S_RSP_RD;
                end else if (t_exp) begin
                    if (r_q.rst == RST_LAST) begin
                        r_d.err = 1'b1;
                        r_d.st  = S_IDLE;
                    end else begin
                        r_d.rst = r_q.rst + RST_W'(1);
                        r_d.idx = '0;
                        r_d.st  = S_CMD_WR;
                    end
                end
            end

            S_RSP_RD: begin
                bus_req   = 1'b1;
                r_d.rsp_v = 1'b1;
                r_d.rsp_b = bus_rdata;
                if (r_q.idx + CNT_W'(1) == r_q.n_rsp) begin
                    r_d.idx  = '0;
                    r_d.done = 1'b1;
                    r_d.st   = S_IDLE;
                end else begin
                    r_d.idx = r_q.idx + CNT_W'(1);
                    r_d.st  = S_RSP_WAIT;
                end
            end

            default: begin
                r_d.st = S_IDLE;
            end
        endcase
    end

    // restart the millisecond base and the window on entry to every wait
    assign arm = is_wait_state(r_d.st) && (r_d.st != r_q.st);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.st != S_IDLE);
    assign done      = r_q.done;
    assign err       = r_q.err;
    assign slow      = r_q.slow;
    assign rsp_valid = r_q.rsp_v;
    assign rsp_data  = r_q.rsp_b;

endmodule

// File: rtl/ec_cmd_seq_checker.sv
module ec_cmd_seq_checker
    import ec_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       err,
    input logic       arg_ready,
    input logic       bus_req,
    input logic       bus_we,
    input logic       bus_addr,
    input logic [7:0] bus_rdata
);
    logic ibf_ok_q;
    logic obf_ok_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ibf_ok_q <= 1'b0;
            obf_ok_q <= 1'b0;
        end else if (bus_req) begin
            if (bus_we) begin
                ibf_ok_q <= 1'b0;
            end else if (bus_addr == PORT_CTRL) begin
                ibf_ok_q <= !bus_rdata[IBF_BIT];
                obf_ok_q <= bus_rdata[OBF_BIT];
            end else begin
                obf_ok_q <= 1'b0;
            end
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req);

    p_write_after_ibf_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we) |-> ibf_ok_q);

    p_ready_only_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        arg_ready |-> busy);

    p_data_read_after_obf_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && bus_addr == PORT_DATA) |-> obf_ok_q);

    p_end_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    p_end_single_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |=> !(done || err));

endmodule

bind ec_cmd_seq ec_cmd_seq_checker u_ec_cmd_seq_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .arg_ready(arg_ready),
    .bus_req  (bus_req),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_rdata(bus_rdata)
);

// File: tb/ec_cmd_seq_bench.sv
module ec_cmd_seq_bench;
    localparam int CPM     = 10;
    localparam int IBF_LAT = 3;
    localparam int MAXR    = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] cmd_i = '0;
    logic [3:0] arg_count = '0;
    logic [3:0] rsp_count = '0;
    logic [7:0] tmo_i = '0;
    logic       arg_valid = 1'b0;
    logic [7:0] arg_data = '0;
    logic       arg_ready, rsp_valid, busy, done, err, slow;
    logic [7:0] rsp_data;
    logic       bus_req, bus_we, bus_addr;
    logic [7:0] bus_wdata, bus_rdata;

    always #5 clk = ~clk;

    ec_cmd_seq #(
        .CYC_PER_MS  (CPM),
        .MAX_RESTARTS(MAXR)
    ) u_ec_cmd_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cmd_byte (cmd_i),
        .arg_count(arg_count),
        .rsp_count(rsp_count),
        .tmo_ms   (tmo_i),
        .arg_valid(arg_valid),
        .arg_data (arg_data),
        .arg_ready(arg_ready),
        .rsp_valid(rsp_valid),
        .rsp_data (rsp_data),
        .busy     (busy),
        .done     (done),
        .err      (err),
        .slow     (slow),
        .bus_req  (bus_req),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int slow_total = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // ---------------- controller model ----------------
    logic       clr = 1'b0;
    int         m_nargs = 0;
    int         m_nrsp = 0;
    int         m_drop = 0;
    int         m_rsp_lat = 5;
    int         m_stale = 0;
    bit         m_ibf_stuck = 0;
    bit         m_obf_stuck = 0;
    logic [7:0] m_rsp [8];

    logic       ibf_r;
    int         ibf_cnt;
    logic [7:0] omem [64];
    logic [5:0] rdp, wrp;
    int         cmd_wr, arg_wr, drain_rd, data_rd, issue, args_left, rsp_tmr;
    logic [7:0] cmd_seen;
    logic [7:0] arg_log [16];
    logic       m_obf;

    assign m_obf = m_obf_stuck || (rdp != wrp);

    always_comb begin
        if (bus_addr) bus_rdata = {6'b0, ibf_r | m_ibf_stuck, m_obf};
        else          bus_rdata = (rdp != wrp) ? omem[rdp] : 8'h00;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n || clr) begin
            ibf_r <= 1'b0; ibf_cnt <= 0; rdp <= '0; wrp <= 6'(m_stale);
            for (int k = 0; k < 8; k++) omem[k] <= 8'hE0 + 8'(k);
            cmd_wr <= 0; arg_wr <= 0; drain_rd <= 0; data_rd <= 0;
            issue <= 0; args_left <= 0; rsp_tmr <= 0; cmd_seen <= '0;
        end else begin
            if (ibf_cnt != 0) begin
                ibf_cnt <= ibf_cnt - 1;
                if (ibf_cnt == 1) ibf_r <= 1'b0;
            end
            if (rsp_tmr != 0) begin
                rsp_tmr <= rsp_tmr - 1;
                if (rsp_tmr == 1) begin
                    for (int k = 0; k < 8; k++)
                        if (k < m_nrsp) omem[wrp + 6'(k)] <= m_rsp[k];
                    wrp <= wrp + 6'(m_nrsp);
                end
            end
            if (bus_req && bus_we) begin
                ibf_r <= 1'b1; ibf_cnt <= IBF_LAT;
                if (bus_addr) begin
                    cmd_seen <= bus_wdata; cmd_wr <= cmd_wr + 1;
                    issue <= issue + 1; args_left <= m_nargs;
                    if (m_nargs == 0 && m_nrsp != 0 && issue + 1 > m_drop) rsp_tmr <= m_rsp_lat;
                end else begin
                    arg_log[arg_wr[3:0]] <= bus_wdata; arg_wr <= arg_wr + 1;
                    args_left <= args_left - 1;
                    if (args_left == 1 && m_nrsp != 0 && issue > m_drop) rsp_tmr <= m_rsp_lat;
                end
            end
            if (bus_req && !bus_we && !bus_addr) begin
                data_rd <= data_rd + 1;
                if (cmd_wr == 0) drain_rd <= drain_rd + 1;
                if (!m_obf_stuck && rdp != wrp) rdp <= rdp + 6'd1;
            end
        end
    end

    // ---------------- scoreboard monitor ----------------
    logic [7:0] exp_q [$];

    always @(negedge clk) begin
        if (rst_n && slow) slow_total++;
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R5", "unexpected response byte", int'(rsp_data), -1);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(rsp_data == e, "R5", "response byte", int'(rsp_data), int'(e));
            end
        end
    end

    // ---------------- driver ----------------
    logic [7:0] t_args [8];

    task automatic run_txn(input logic [7:0] c, input int na, input int nr,
                           input int tmo, input bit feed, input bit expect_rsp,
                           output int lat, output bit got_done, output bit got_err);
        int n;
        m_nargs = na; m_nrsp = nr;
        clr = 1'b1; @(negedge clk); clr = 1'b0;
        if (expect_rsp) for (int k = 0; k < nr; k++) exp_q.push_back(m_rsp[k]);
        cmd_i = c; arg_count = 4'(na); rsp_count = 4'(nr); tmo_i = 8'(tmo);
        start = 1'b1; @(negedge clk); start = 1'b0;
        n = cyc;
        if (feed) begin
            for (int k = 0; k < na; k++) begin
                arg_valid = 1'b1; arg_data = t_args[k];
                forever begin
                    if (arg_ready) begin @(negedge clk); break; end
                    @(negedge clk);
                end
            end
            arg_valid = 1'b0;
        end
        begin
            int guard = 0;
            while (!(done || err) && guard < 5000) begin @(negedge clk); guard++; end
            if (guard >= 5000) chk(0, "R11", "transaction never ended", 0, 1);
        end
        lat = cyc - n; got_done = done; got_err = err;
        chk(!(done && err), "R11", "done and err together", int'(done & err), 0);
        @(negedge clk);
        chk(!(done || err), "R11", "end pulse longer than one cycle", int'(done | err), 0);
    endtask

    task automatic model_defaults();
        m_drop = 0; m_rsp_lat = 5; m_stale = 0; m_ibf_stuck = 0; m_obf_stuck = 0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        chk(0, "R11", "watchdog expired", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int lat; bit d, e; int s0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !err && !slow, "R1", "status after reset", int'(busy|done|err|slow), 0);
        chk(!bus_req && !arg_ready && !rsp_valid, "R1", "bus idle after reset", int'(bus_req), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy && !bus_req, "R1", "idle without start", int'(busy|bus_req), 0);

        // R3 R5 single response, no args
        model_defaults(); m_rsp[0] = 8'h5A;
        run_txn(8'h08, 0, 1, 20, 1, 1, lat, d, e);
        chk(d && !e, "R5", "single response done", int'(d), 1);
        chk(cmd_seen == 8'h08 && cmd_wr == 1, "R3", "command byte written", int'(cmd_seen), 8'h08);
        chk(exp_q.size() == 0, "R5", "responses delivered", exp_q.size(), 0);

        // R4 three args in order, two responses
        model_defaults(); m_rsp[0] = 8'hA1; m_rsp[1] = 8'hB2;
        t_args[0] = 8'h11; t_args[1] = 8'h22; t_args[2] = 8'h33;
        run_txn(8'h31, 3, 2, 20, 1, 1, lat, d, e);
        chk(d, "R4", "args transaction done", int'(d), 1);
        chk(arg_wr == 3, "R4", "arg byte count", arg_wr, 3);
        chk(arg_log[0] == 8'h11 && arg_log[1] == 8'h22 && arg_log[2] == 8'h33,
            "R4", "arg order", int'(arg_log[2]), 8'h33);
        chk(exp_q.size() == 0, "R5", "two responses delivered", exp_q.size(), 0);

        // R3 command only
        model_defaults();
        run_txn(8'h42, 0, 0, 20, 1, 0, lat, d, e);
        chk(d && cmd_seen == 8'h42, "R3", "command-only transaction", int'(cmd_seen), 8'h42);

        // R2 drain three stale bytes
        model_defaults(); m_stale = 3; m_rsp[0] = 8'h77;
        run_txn(8'h10, 0, 1, 20, 1, 1, lat, d, e);
        chk(d && !e, "R2", "drain then done", int'(d), 1);
        chk(drain_rd == 3, "R2", "stale reads", drain_rd, 3);
        chk(exp_q.size() == 0, "R5", "stale not delivered", exp_q.size(), 0);

        // R2 drain never empties
        model_defaults(); m_stale = 1; m_obf_stuck = 1;
        run_txn(8'h10, 0, 1, 20, 0, 0, lat, d, e);
        chk(e && !d, "R2", "drain limit error", int'(e), 1);
        chk(drain_rd == 10, "R2", "drain read count", drain_rd, 10);
        chk(cmd_wr == 0, "R2", "no command after drain failure", cmd_wr, 0);

        // R6 R7 stuck input buffer, invalid timeout selects 20 ms
        model_defaults(); m_ibf_stuck = 1;
        run_txn(8'h20, 0, 1, 0, 0, 0, lat, d, e);
        chk(e, "R7", "quiesce timeout error", int'(e), 1);
        chk(lat >= 20*CPM && lat <= 20*CPM + 4, "R6", "default timeout latency", lat, 20*CPM + 2);
        chk(cmd_wr == 0, "R7", "no command on quiesce timeout", cmd_wr, 0);

        // R6 programmed 5 ms
        model_defaults(); m_ibf_stuck = 1;
        run_txn(8'h20, 0, 1, 5, 0, 0, lat, d, e);
        chk(e && lat >= 5*CPM && lat <= 5*CPM + 4, "R6", "5 ms timeout latency", lat, 5*CPM + 2);

        // R8 restart with argument replay
        model_defaults(); m_drop = 1; m_rsp_lat = 20; m_rsp[0] = 8'h99;
        t_args[0] = 8'hC1; t_args[1] = 8'hC2;
        run_txn(8'h55, 2, 1, 5, 1, 1, lat, d, e);
        chk(d && !e, "R8", "restart then done", int'(d), 1);
        chk(cmd_wr == 2, "R8", "command reissued once", cmd_wr, 2);
        chk(arg_wr == 4 && arg_log[2] == 8'hC1 && arg_log[3] == 8'hC2,
            "R8", "args replayed", arg_wr, 4);
        chk(data_rd == 1 && exp_q.size() == 0, "R8", "single response after restart", data_rd, 1);

        // R9 restart limit
        model_defaults(); m_drop = 99;
        run_txn(8'h56, 0, 1, 3, 0, 0, lat, d, e);
        chk(e && !d, "R9", "restart limit error", int'(e), 1);
        chk(cmd_wr == MAXR + 1, "R9", "command writes", cmd_wr, MAXR + 1);

        // R10 R11 slow response, start while busy ignored
        model_defaults(); m_rsp_lat = 250; m_rsp[0] = 8'h3C;
        s0 = slow_total;
        fork
            run_txn(8'h61, 0, 1, 40, 1, 1, lat, d, e);
            begin
                repeat (60) @(negedge clk);
                cmd_i = 8'h7E; start = 1'b1; @(negedge clk); start = 1'b0;
            end
        join
        chk(d && !e, "R10", "slow wait still succeeds", int'(d), 1);
        chk(slow_total - s0 == 1, "R10", "slow pulses", slow_total - s0, 1);
        chk(cmd_wr == 1 && cmd_seen == 8'h61, "R11", "start while busy ignored", cmd_wr, 1);
        repeat (3) @(negedge clk);
        chk(!busy, "R11", "no second transaction", int'(busy), 0);

        // R10 long timeout, quick response
        model_defaults(); m_rsp_lat = 100; m_rsp[0] = 8'h3D;
        s0 = slow_total;
        run_txn(8'h62, 0, 1, 40, 1, 1, lat, d, e);
        chk(d && slow_total == s0, "R10", "no slow within base window", slow_total - s0, 0);

        // R10 base timeout never slow
        model_defaults(); m_rsp_lat = 150; m_rsp[0] = 8'h3E;
        s0 = slow_total;
        run_txn(8'h63, 0, 1, 20, 1, 1, lat, d, e);
        chk(d && slow_total == s0, "R10", "no slow at base timeout", slow_total - s0, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule